// File: doc/BRIEF.md
# Calendar Time Counter

This block keeps wall-clock time and date. It holds seconds, minutes, hours, day of week, day of month, month, a two-digit year and a century field. A sub-second divider counts a 32.768 kHz tick enable, and the calendar advances by one second each time the divider wraps. Carries ripple through the fields. Day of month wraps at the length of the current month, and February has 29 days when the year is a multiple of four.

Each field is shown either as plain binary or as packed BCD, chosen by a mode input. Hours are shown in 24-hour or 12-hour form. In 12-hour form bit 7 of the hours field marks PM. The host loads any field directly, writing in the current encoding. A busy flag warns the host that an update is about to happen, during the last few ticks before each rollover. The host can freeze the fields. It can also hold the divider in reset, and the first update after release then comes half a second later.

Internally the fields are binary. Encoding is applied at the outputs and decoding at the write port, so a change of mode reformats every field at once.

Top module: `rtc_calendar_counter`

## Requirements
- R1: After reset the fields read 00:00:00, weekday 1, day 1, month 1, year 0 and century 0. Both busy_o and update_o are low.
- R2: While counting, each TICKS_PER_SEC accepted ticks advance seconds by one. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R3: When binary_mode_i is 0, every field is packed BCD, with tens in bits 7:4 and units in bits 3:0. When binary_mode_i is 1, every field is plain binary.
- R4: When hour24_i is 0, hours show as 12, 1 to 11 with bit 7 = 0 for the AM hours 0 to 11. They show as 12, 1 to 11 with bit 7 = 1 for the PM hours 12 to 23. Writes decode the same way. When hour24_i is 1, hours show 0 to 23 with no flag.
- R5: Day of week advances once per day carry and wraps from 7 to 1.
- R6: Day of month wraps to 1 after the month's last day: 31, or 30 for months 4, 6, 9 and 11. February ends at day 29 when year mod 4 is 0 and at day 28 otherwise. Month wraps from 12 to 1 and carries into the year. Year wraps from 99 to 0 and increments the century.
- R7: busy_o is high during the last BUSY_TICKS tick positions before a rollover. It drops with the update.
- R8: update_o pulses for exactly one cycle after each divider rollover, including while the fields are frozen.
- R9: While freeze_i is 1, the fields do not advance and busy_o stays low.
- R10: While div_ctl_i[2:1] is 2'b11, the divider is held in reset: no update occurs and busy_o is low. After release to a counting code, the first update follows after TICKS_PER_SEC/2 ticks.
- R11: div_ctl_i codes above 3'b010 that are not in divider reset (3'b011, 3'b100, 3'b101) hold the divider and the fields, with no update.
- R12: A write loads the field selected by wr_sel_i with wr_data_i. The select codes are 0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year and 7 century. The next full second is restarted from that cycle, except while the divider is held in reset.
- R13: Cycles with tick_i low neither advance the divider nor the fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz tick enable |
| binary_mode_i | input | 1 | 1 binary fields, 0 BCD fields |
| hour24_i | input | 1 | 1 24-hour form, 0 12-hour form |
| freeze_i | input | 1 | Stop the fields from advancing |
| div_ctl_i | input | 3 | Divider control: 000 to 010 count, x11x reset, others hold |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for a write |
| wr_data_i | input | 8 | Write data in current encoding |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| century_o | output | 8 | Century |
| busy_o | output | 1 | Update imminent |
| update_o | output | 1 | One-cycle pulse after each rollover |

## Verification
The bound checker watches several rules on every cycle:
- busy_o is low under divider reset.
- update_o appears only after a counting cycle with tick_i high, and never on two cycles in a row.
- An unfrozen update is always preceded by busy_o.
- Frozen fields hold still.
- Seconds below 59 step by exactly one per update.

Calendar carries, month lengths and leap years, the century carry, both encodings, the 12-hour mapping of noon and midnight, and the half-second delay after divider release depend on chosen times and modes. Only the bench's sweeps show these.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned NUM_FLDS = 8;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_CENT = 3'd7
  } fld_e;

  typedef logic [NUM_FLDS-1:0][7:0] flds_t;

  localparam flds_t FLDS_RESET = {8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] days_in_month(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                      return (yr[1:0] == 2'd0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_sub_second.sv
module rtc_sub_second #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned BUSY_TICKS    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic div_rst_i,
  input  logic freeze_i,
  input  logic restart_i,
  output logic busy_o,
  output logic roll_o,
  output logic update_o
);

  localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF      = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] BUSY_FROM = CW'(TICKS_PER_SEC - BUSY_TICKS);

  logic [CW-1:0] sub_q;
  logic          upd_q;

  assign roll_o   = tick_i & run_i & ~restart_i & (sub_q == LAST);
  assign busy_o   = run_i & ~freeze_i & (sub_q >= BUSY_FROM);
  assign update_o = upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= roll_o;
      // divider reset preloads half a second so release delays the first update
      if (div_rst_i)               sub_q <= HALF;
      else if (restart_i)          sub_q <= '0;
      else if (tick_i && run_i)    sub_q <= (sub_q == LAST) ? '0 : sub_q + CW'(1);
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_en_i,
  input  fld_e       wr_sel_i,
  input  logic [7:0] wr_val_i,
  output flds_t      flds_o
);

  flds_t flds_q;
  flds_t nxt;

  always_comb begin
    nxt = flds_q;
    if (flds_q[FLD_SEC] >= 8'd59) begin
      nxt[FLD_SEC] = 8'd0;
      if (flds_q[FLD_MIN] >= 8'd59) begin
        nxt[FLD_MIN] = 8'd0;
        if (flds_q[FLD_HOUR] >= 8'd23) begin
          nxt[FLD_HOUR] = 8'd0;
          nxt[FLD_WDAY] = (flds_q[FLD_WDAY] >= 8'd7) ? 8'd1 : flds_q[FLD_WDAY] + 8'd1;
          if (flds_q[FLD_MDAY] >= days_in_month(flds_q[FLD_MON], flds_q[FLD_YEAR])) begin
            nxt[FLD_MDAY] = 8'd1;
            if (flds_q[FLD_MON] >= 8'd12) begin
              nxt[FLD_MON] = 8'd1;
              if (flds_q[FLD_YEAR] >= 8'd99) begin
                nxt[FLD_YEAR] = 8'd0;
                nxt[FLD_CENT] = (flds_q[FLD_CENT] >= 8'd99) ? 8'd0 : flds_q[FLD_CENT] + 8'd1;
              end else begin
                nxt[FLD_YEAR] = flds_q[FLD_YEAR] + 8'd1;
              end
            end else begin
              nxt[FLD_MON] = flds_q[FLD_MON] + 8'd1;
            end
          end else begin
            nxt[FLD_MDAY] = flds_q[FLD_MDAY] + 8'd1;
          end
        end else begin
          nxt[FLD_HOUR] = flds_q[FLD_HOUR] + 8'd1;
        end
      end else begin
        nxt[FLD_MIN] = flds_q[FLD_MIN] + 8'd1;
      end
    end else begin
      nxt[FLD_SEC] = flds_q[FLD_SEC] + 8'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flds_q <= FLDS_RESET;
    else if (wr_en_i) flds_q[wr_sel_i] <= wr_val_i;
    else if (adv_i)   flds_q <= nxt;
  end

  assign flds_o = flds_q;

endmodule

// File: rtl/rtc_field_codec.sv
module rtc_field_codec
  import rtc_cal_pkg::*;
(
  input  logic       binary_mode_i,
  input  logic       hour24_i,
  input  flds_t      flds_i,
  input  fld_e       wr_sel_i,
  input  logic [7:0] wr_data_i,
  output flds_t      enc_o,
  output logic [7:0] wr_val_o
);

  for (genvar g = 0; g < NUM_FLDS; g++) begin : g_enc
    if (g == int'(FLD_HOUR)) begin : g_hour
      logic [7:0] h12;
      logic [7:0] h12_enc;
      logic [7:0] h24_enc;
      logic       pm;
      always_comb begin
        pm = (flds_i[g] >= 8'd12);
        if (flds_i[g] == 8'd0)       h12 = 8'd12;
        else if (flds_i[g] > 8'd12)  h12 = flds_i[g] - 8'd12;
        else                         h12 = flds_i[g];
        h12_enc = binary_mode_i ? h12 : bin_to_bcd(h12);
        h24_enc = binary_mode_i ? flds_i[g] : bin_to_bcd(flds_i[g]);
      end
      assign enc_o[g] = hour24_i ? h24_enc : {pm, h12_enc[6:0]};
    end else begin : g_plain
      assign enc_o[g] = binary_mode_i ? flds_i[g] : bin_to_bcd(flds_i[g]);
    end
  end

  logic       hr12_wr;
  logic [7:0] raw;
  logic [7:0] dec;

  always_comb begin
    hr12_wr = (wr_sel_i == FLD_HOUR) && !hour24_i;
    raw     = hr12_wr ? {1'b0, wr_data_i[6:0]} : wr_data_i;
    dec     = binary_mode_i ? raw : bcd_to_bin(raw);
    if (hr12_wr) wr_val_o = ((dec == 8'd12) ? 8'd0 : dec) + (wr_data_i[7] ? 8'd12 : 8'd0);
    else         wr_val_o = dec;
  end

endmodule

// File: rtl/rtc_calendar_counter.sv
module rtc_calendar_counter
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned BUSY_TICKS    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       binary_mode_i,
  input  logic       hour24_i,
  input  logic       freeze_i,
  input  logic [2:0] div_ctl_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] century_o,
  output logic       busy_o,
  output logic       update_o
);

  logic       run;
  logic       div_rst;
  logic       roll;
  logic [7:0] wr_val;
  fld_e       wr_sel;
  flds_t      cal_flds;
  flds_t      enc_flds;

  assign run     = (div_ctl_i <= 3'b010);
  assign div_rst = &div_ctl_i[2:1];
  assign wr_sel  = fld_e'(wr_sel_i);

  rtc_sub_second #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .BUSY_TICKS   (BUSY_TICKS)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run),
    .div_rst_i(div_rst),
    .freeze_i (freeze_i),
    .restart_i(wr_en_i),
    .busy_o   (busy_o),
    .roll_o   (roll),
    .update_o (update_o)
  );

  rtc_calendar u_cal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (roll & ~freeze_i),
    .wr_en_i (wr_en_i),
    .wr_sel_i(wr_sel),
    .wr_val_i(wr_val),
    .flds_o  (cal_flds)
  );

  rtc_field_codec u_codec (
    .binary_mode_i(binary_mode_i),
    .hour24_i     (hour24_i),
    .flds_i       (cal_flds),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data_i),
    .enc_o        (enc_flds),
    .wr_val_o     (wr_val)
  );

  assign sec_o     = enc_flds[FLD_SEC];
  assign min_o     = enc_flds[FLD_MIN];
  assign hour_o    = enc_flds[FLD_HOUR];
  assign wday_o    = enc_flds[FLD_WDAY];
  assign mday_o    = enc_flds[FLD_MDAY];
  assign month_o   = enc_flds[FLD_MON];
  assign year_o    = enc_flds[FLD_YEAR];
  assign century_o = enc_flds[FLD_CENT];

endmodule

// File: rtl/rtc_calendar_counter_chk.sv
module rtc_calendar_counter_chk
  import rtc_cal_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       freeze_i,
  input logic [2:0] div_ctl_i,
  input logic       wr_en_i,
  input logic       busy_o,
  input logic       update_o,
  input flds_t      time_flds
);

  AST_DIVRST_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_ctl_i[2:1] == 2'b11) |-> !busy_o); // R10

  AST_UPDATE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(div_ctl_i <= 3'b010)); // R11

  AST_NO_TICK_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !update_o); // R13

  AST_BUSY_BEFORE_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o && !$past(freeze_i)) |-> $past(busy_o)); // R7

  AST_UPDATE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o); // R8

  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !wr_en_i) |=> $stable(time_flds)); // R9

  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o && !$past(freeze_i) && ($past(time_flds[FLD_SEC]) < 8'd59))
      |-> (time_flds[FLD_SEC] == $past(time_flds[FLD_SEC]) + 8'd1)); // R2

endmodule

bind rtc_calendar_counter rtc_calendar_counter_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .freeze_i (freeze_i),
  .div_ctl_i(div_ctl_i),
  .wr_en_i  (wr_en_i),
  .busy_o   (busy_o),
  .update_o (update_o),
  .time_flds(cal_flds)
);

// File: tb/rtc_calendar_counter_tb.sv
module rtc_calendar_counter_tb_top;

  localparam int T = 32;
  localparam int B = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       bm = 1'b0;
  logic       h24 = 1'b1;
  logic       frz = 1'b0;
  logic [2:0] ctl = 3'b010;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o, century_o;
  logic       busy_o, update_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int es, em, eh, ew, ed, emo, ey, ec;

  always #5 clk = ~clk;

  rtc_calendar_counter #(.TICKS_PER_SEC(T), .BUSY_TICKS(B)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .binary_mode_i(bm), .hour24_i(h24),
    .freeze_i(frz), .div_ctl_i(ctl), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o),
    .month_o(month_o), .year_o(year_o), .century_o(century_o), .busy_o(busy_o), .update_o(update_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int enc(input int v);
    return bm ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int enc_hr(input int h);
    int h12;
    if (h24) return enc(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12) | ((h >= 12) ? 128 : 0);
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic adv_model();
    es++;
    if (es == 60) begin
      es = 0; em++;
      if (em == 60) begin
        em = 0; eh++;
        if (eh == 24) begin
          eh = 0; ew = (ew == 7) ? 1 : ew + 1; ed++;
          if (ed > dim(emo, ey)) begin
            ed = 1; emo++;
            if (emo == 13) begin
              emo = 1; ey++;
              if (ey == 100) begin ey = 0; ec = (ec + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input int d);
    wr_en = 1'b1; wr_sel = sel[2:0]; wr_data = d[7:0];
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic load_exp();
    wr(7, enc(ec)); wr(6, enc(ey)); wr(5, enc(emo)); wr(4, enc(ed));
    wr(3, enc(ew)); wr(2, enc_hr(eh)); wr(1, enc(em)); wr(0, enc(es));
  endtask

  task automatic check_fields(input string req);
    chk(req, "sec",  sec_o,  enc(es));
    chk(req, "min",  min_o,  enc(em));
    chk(req, "hour", hour_o, enc_hr(eh));
    chk(req, "wday", wday_o, enc(ew));
    chk(req, "mday", mday_o, enc(ed));
    chk(req, "mon",  month_o, enc(emo));
    chk(req, "year", year_o, enc(ey));
    chk(req, "cent", century_o, enc(ec));
  endtask

  // write the expected time, then step exactly one second and compare
  task automatic step_check(input string req);
    load_exp();
    check_fields("R12");
    cyc(T - B - 1);
    chk("R7", "busy early", busy_o, 0);
    cyc(1);
    chk("R7", "busy window", busy_o, 1);
    cyc(B - 1);
    chk("R7", "busy last", busy_o, 1);
    chk("R2", "sec before roll", sec_o, enc(es));
    adv_model();
    cyc(1);
    check_fields(req);
    chk("R8", "update pulse", update_o, 1);
    chk("R7", "busy after", busy_o, 0);
    cyc(1);
    chk("R8", "update end", update_o, 0);
  endtask

  task automatic count_idle(input string req, input int n, input int exp_upd);
    int ups = 0;
    int busy_seen = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      ups += int'(update_o);
      busy_seen += int'(busy_o);
    end
    chk(req, "updates", ups, exp_upd);
    chk(req, "busy cycles", busy_seen, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int yrs[4] = '{0, 1, 3, 99};
    cyc(3);
    rst_n = 1'b1;
    es = 0; em = 0; eh = 0; ew = 1; ed = 1; emo = 1; ey = 0; ec = 0;
    check_fields("R1");
    chk("R1", "busy", busy_o, 0);
    chk("R1", "update", update_o, 0);

    // R3: one stored value seen in both encodings
    wr(1, 8'h59);
    chk("R3", "bcd min", min_o, 8'h59);
    bm = 1'b1; cyc(1);
    chk("R3", "bin min", min_o, 59);
    // R4: midnight and 13h in 12-hour BCD
    bm = 1'b0; h24 = 1'b0;
    wr(2, 8'h12); chk("R4", "midnight", hour_o, 8'h12);
    wr(2, 8'h81); h24 = 1'b1; cyc(1); chk("R4", "1pm as 24h", hour_o, 8'h13);

    // R2 R4 hour carries through a whole day, all modes
    for (int mv = 0; mv < 4; mv++) begin
      bm = mv[0]; h24 = mv[1];
      for (int h = 0; h < 24; h++) begin
        es = 59; em = 59; eh = h; ew = 3; ed = 10; emo = 5; ey = 7; ec = 20;
        step_check("R4");
      end
    end

    // R5 R6 month ends, leap years, century carry
    for (int mv = 0; mv < 4; mv++) begin
      bm = mv[0]; h24 = mv[1];
      for (int yi = 0; yi < 4; yi++) begin
        for (int mo = 1; mo <= 12; mo++) begin
          ey = yrs[yi]; emo = mo; ed = dim(mo, ey); ec = 19;
          es = 59; em = 59; eh = 23; ew = ((mo + yi) % 7) + 1;
          step_check("R6");
        end
      end
    end
    // R5: explicit weekday 7 wrap
    bm = 1'b0; h24 = 1'b1;
    es = 59; em = 59; eh = 23; ew = 7; ed = 4; emo = 3; ey = 10; ec = 20;
    step_check("R5");
    chk("R5", "wday wrap", wday_o, 1);

    // R9 frozen: fields hold, busy low, update still pulses
    es = 30; em = 12; eh = 8; ew = 2; ed = 15; emo = 6; ey = 24; ec = 20;
    load_exp();
    frz = 1'b1;
    count_idle("R9", 3 * T, 3);
    check_fields("R9");
    frz = 1'b0;

    // R10 divider reset, write during reset, half-second release
    ctl = 3'b110;
    count_idle("R10", 3 * T, 0);
    check_fields("R10");
    es = 5; wr(0, enc(es));
    ctl = 3'b010;
    cyc(T / 2 - 1);
    chk("R10", "no early update", update_o, 0);
    cyc(1);
    chk("R10", "half-second update", update_o, 1);
    adv_model();
    check_fields("R10");

    // R11 hold codes
    ctl = 3'b011; count_idle("R11", 2 * T, 0); check_fields("R11");
    ctl = 3'b100; count_idle("R11", 2 * T, 0); check_fields("R11");
    ctl = 3'b101; count_idle("R11", 2 * T, 0); check_fields("R11");
    ctl = 3'b010;

    // R13 no ticks, no progress
    load_exp();
    tick = 1'b0;
    count_idle("R13", 3 * T, 0);
    check_fields("R13");
    tick = 1'b1;
    step_check("R13");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule